// File: doc/BRIEF.md
# Interrupt-Driven Micro-Transfer Server

This block answers selected interrupt sources with a short data move in place of a software handler. Each source has a two-byte entry in a vector table held in a byte-wide register RAM, and that entry points to an eight-byte control block in the same RAM. When a selected source fires, the engine reads the vector and then the whole control block. It moves one item, or a block of items, from the source pointer to the destination pointer, and writes the decremented count and the advanced pointers back. It then ends the service with a one-clock done pulse.

Each source has a select bit and a service-pending bit. A source whose select bit is clear is not served by transfer: its interrupt is passed on as a one-clock bypass pulse for normal handling. When a service brings the count to zero, the hardware clears the select bit and sets the service-pending bit. That bit is the end-of-service request. Software re-arms the source by rewriting its control block and setting the select bit again.

The RAM port is a valid/ready request channel. The engine holds address, write flag and write data stable while valid is high and ready is low. A request counts as accepted on a clock where both are high. A write is complete on acceptance. A read returns its data with a one-clock `mem_rvalid_i` pulse, one or more cycles after acceptance. The engine is always ready for that response and keeps at most one read outstanding.

Top module: `mts_server`

## Requirements
- R1: When several sources have both pending and select bits set, the lowest-numbered one is served first, and only one service runs at a time.
- R2: The control block base of source s is read as two bytes at VEC_BASE + 2*s (low byte first, then high byte).
- R3: A base whose three low bits are not zero gives a one-clock `err_o` pulse with `svc_src_o` naming the source. It drops that pending request and writes nothing to RAM.
- R4: Control block layout: byte 0 service count, byte 1 control, bytes 2-3 source pointer (low, high), bytes 4-5 destination pointer (low, high), byte 6 block length, byte 7 unused. All eight bytes are read.
- R5: Control bit 0 selects 16-bit word items (1) or byte items (0). A word is moved low byte first at pointer, pointer+1. Bit 1 enables source pointer increment and bit 2 enables destination pointer increment, each by 2 for words and by 1 for bytes.
- R6: Control bit 3 selects block mode, which moves as many items as the block length (0 moves none). Otherwise exactly one item is moved.
- R7: Before the done pulse, the count minus one (modulo 256) is written to byte 0, and the advanced pointers are written to bytes 2-5.
- R8: When the written-back count is zero, the cycle after the done pulse shows that source's select bit clear and its service-pending bit set.
- R9: An interrupt on a source whose select bit is clear produces a `bypass_o` pulse for that source on the next cycle. It causes no RAM traffic and no service.
- R10: `done_o` is high for exactly one clock per completed service, with `svc_src_o` naming the source.
- R11: While `mem_valid_o` is high and `mem_ready_i` is low, the request (valid, address, write flag, write data) stays unchanged.
- R12: `sel_set_i` sets select bits and `srv_clr_i` clears service-pending bits, both effective on the next clock. Reset clears all select and service-pending bits. An expiry clear of a select bit wins over a set in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_i | input | NSRC | Interrupt request per source, one clock per event |
| sel_set_i | input | NSRC | Sets select bits (transfer service enabled) |
| srv_clr_i | input | NSRC | Clears service-pending bits |
| sel_o | output | NSRC | Select bits |
| srv_o | output | NSRC | Service-pending bits (end-of-service requests) |
| bypass_o | output | NSRC | Interrupt passed to normal handling |
| done_o | output | 1 | One-clock pulse at the end of a service |
| err_o | output | 1 | One-clock pulse for a misaligned control block base |
| svc_src_o | output | SW | Source served, valid with done_o or err_o |
| mem_valid_o | output | 1 | RAM request valid |
| mem_ready_i | input | 1 | RAM request accepted |
| mem_write_o | output | 1 | Request is a write |
| mem_addr_o | output | AW | Byte address |
| mem_wdata_o | output | 8 | Write data |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 8 | Read data |

## Verification
The assertions check on every cycle that a stalled RAM request holds still, that the picked source is the lowest eligible one, and that no control block fetch starts from a misaligned base. They also check that done never lasts two clocks, that an expiry leaves select clear and service-pending set, and that an unselected interrupt becomes a bypass pulse without becoming pending. Only the bench scenarios can show that the moved bytes, the advanced pointers and the written-back count match the control block semantics for byte, word, block, fixed-pointer and zero-length cases under random stalls and read latency. The same holds for re-arming a source after it expires.

// File: rtl/mts_pkg.sv
package mts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_VEC, ST_CHK, ST_CB, ST_RD, ST_WR, ST_WB, ST_FIN
  } eng_st_e;

  // control byte bit positions
  localparam int CTL_WORD = 0;
  localparam int CTL_SINC = 1;
  localparam int CTL_DINC = 2;
  localparam int CTL_BLK  = 3;

  // control block byte offsets
  localparam logic [2:0] CB_CNT  = 3'd0;
  localparam logic [2:0] CB_CTL  = 3'd1;
  localparam logic [2:0] CB_SLO  = 3'd2;
  localparam logic [2:0] CB_SHI  = 3'd3;
  localparam logic [2:0] CB_DLO  = 3'd4;
  localparam logic [2:0] CB_DHI  = 3'd5;
  localparam logic [2:0] CB_LEN  = 3'd6;
  localparam logic [2:0] CB_LAST = 3'd7;
endpackage

// File: rtl/mts_src_regs.sv
module mts_src_regs #(
  parameter int NSRC = 4,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_i,
  input  logic [NSRC-1:0] sel_set_i,
  input  logic [NSRC-1:0] srv_clr_i,
  input  logic            fin_i,
  input  logic [SW-1:0]   fin_src_i,
  input  logic            fin_expire_i,
  output logic [NSRC-1:0] pend_o,
  output logic [NSRC-1:0] sel_o,
  output logic [NSRC-1:0] srv_o,
  output logic [NSRC-1:0] bypass_o
);
  logic [NSRC-1:0] fin_mask, exp_mask;

  assign fin_mask = fin_i ? (NSRC'(1) << fin_src_i) : '0;
  assign exp_mask = fin_expire_i ? fin_mask : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_o   <= '0;
      sel_o    <= '0;
      srv_o    <= '0;
      bypass_o <= '0;
    end else begin
      pend_o   <= (pend_o & ~fin_mask) | (irq_i & sel_o);
      sel_o    <= (sel_o | sel_set_i) & ~exp_mask;
      srv_o    <= (srv_o & ~srv_clr_i) | exp_mask;
      bypass_o <= irq_i & ~sel_o;
    end
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_chk
    a_r8_expire_handback: assert property (@(posedge clk) disable iff (!rst_n)
      (fin_i && fin_expire_i && fin_src_i == SW'(i)) |=> (srv_o[i] && !sel_o[i]));
    a_r9_unselected_bypass: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_i[i] && !sel_o[i]) |=> (bypass_o[i] && !pend_o[i]));
  end
endmodule

// File: rtl/mts_prio_pick.sv
module mts_prio_pick #(
  parameter int NSRC = 4,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req_i,
  output logic            gnt_valid_o,
  output logic [SW-1:0]   gnt_idx_o
);
  always_comb begin
    gnt_idx_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (req_i[i]) gnt_idx_o = SW'(i);
    end
  end
  assign gnt_valid_o = |req_i;
endmodule

// File: rtl/mts_engine.sv
module mts_engine
  import mts_pkg::*;
#(
  parameter int          NSRC     = 4,
  parameter int          AW       = 16,
  parameter logic [15:0] VEC_BASE = 16'h0040,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pick_valid_i,
  input  logic [SW-1:0] pick_idx_i,
  output logic          mem_valid_o,
  input  logic          mem_ready_i,
  output logic          mem_write_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [7:0]    mem_wdata_o,
  input  logic          mem_rvalid_i,
  input  logic [7:0]    mem_rdata_i,
  output logic          done_o,
  output logic          err_o,
  output logic [SW-1:0] svc_src_o,
  output logic          fin_o,
  output logic          fin_expire_o
);
  eng_st_e         st;
  logic [SW-1:0]   src_q;
  logic [2:0]      idx;
  logic            waiting;
  logic [15:0]     base_q, sptr, dptr;
  logic [7:0]      cnt_q, len_q, items_q;
  logic [3:0]      ctl_q;
  logic [1:0][7:0] hold_q;

  logic        busy_mem, accept, rsp, step, misaligned;
  logic [2:0]  last_idx, wb_off;
  logic [15:0] addr16, step_sz;
  logic [7:0]  cnt_new;

  assign busy_mem   = (st == ST_VEC) || (st == ST_CB) || (st == ST_RD) ||
                      (st == ST_WR)  || (st == ST_WB);
  assign mem_valid_o = busy_mem && !waiting;
  assign mem_write_o = (st == ST_WR) || (st == ST_WB);
  assign accept     = mem_valid_o && mem_ready_i;
  assign rsp        = waiting && mem_rvalid_i;
  assign step       = (accept && mem_write_o) || rsp;
  assign misaligned = (base_q[2:0] != 3'd0);
  assign cnt_new    = cnt_q - 8'd1;
  assign step_sz    = ctl_q[CTL_WORD] ? 16'd2 : 16'd1;
  assign wb_off     = (idx == 3'd0) ? CB_CNT : idx + 3'd1;

  always_comb begin
    case (st)
      ST_VEC:  last_idx = 3'd1;
      ST_CB:   last_idx = CB_LAST;
      ST_WB:   last_idx = 3'd4;
      default: last_idx = ctl_q[CTL_WORD] ? 3'd1 : 3'd0;
    endcase
  end

  always_comb begin
    case (st)
      ST_VEC:  addr16 = VEC_BASE + (16'(src_q) << 1) + 16'(idx);
      ST_CB:   addr16 = base_q + 16'(idx);
      ST_RD:   addr16 = sptr + 16'(idx);
      ST_WR:   addr16 = dptr + 16'(idx);
      ST_WB:   addr16 = base_q + 16'(wb_off);
      default: addr16 = base_q;
    endcase
  end
  assign mem_addr_o = AW'(addr16);

  always_comb begin
    mem_wdata_o = 8'h00;
    if (st == ST_WR) begin
      mem_wdata_o = hold_q[idx[0]];
    end else if (st == ST_WB) begin
      case (idx)
        3'd0:    mem_wdata_o = cnt_new;
        3'd1:    mem_wdata_o = sptr[7:0];
        3'd2:    mem_wdata_o = sptr[15:8];
        3'd3:    mem_wdata_o = dptr[7:0];
        default: mem_wdata_o = dptr[15:8];
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_IDLE;
      src_q   <= '0;
      idx     <= '0;
      waiting <= 1'b0;
      base_q  <= '0;
      sptr    <= '0;
      dptr    <= '0;
      cnt_q   <= '0;
      len_q   <= '0;
      items_q <= '0;
      ctl_q   <= '0;
      hold_q  <= '0;
    end else begin
      if (accept && !mem_write_o) waiting <= 1'b1;
      if (rsp) begin
        waiting <= 1'b0;
        case (st)
          ST_VEC: begin
            if (idx[0]) base_q[15:8] <= mem_rdata_i;
            else        base_q[7:0]  <= mem_rdata_i;
          end
          ST_CB: begin
            case (idx)
              CB_CNT:  cnt_q       <= mem_rdata_i;
              CB_CTL:  ctl_q       <= mem_rdata_i[3:0];
              CB_SLO:  sptr[7:0]   <= mem_rdata_i;
              CB_SHI:  sptr[15:8]  <= mem_rdata_i;
              CB_DLO:  dptr[7:0]   <= mem_rdata_i;
              CB_DHI:  dptr[15:8]  <= mem_rdata_i;
              CB_LEN:  len_q       <= mem_rdata_i;
              default: ;
            endcase
          end
          ST_RD:   hold_q[idx[0]] <= mem_rdata_i;
          default: ;
        endcase
      end

      case (st)
        ST_IDLE: begin
          if (pick_valid_i) begin
            src_q <= pick_idx_i;
            idx   <= '0;
            st    <= ST_VEC;
          end
        end
        ST_CHK: st <= misaligned ? ST_IDLE : ST_CB;
        ST_FIN: st <= ST_IDLE;
        default: begin
          if (step) begin
            if (idx != last_idx) begin
              idx <= idx + 3'd1;
            end else begin
              idx <= '0;
              case (st)
                ST_VEC: st <= ST_CHK;
                ST_CB: begin
                  items_q <= ctl_q[CTL_BLK] ? len_q : 8'd1;
                  st      <= (ctl_q[CTL_BLK] && len_q == 8'd0) ? ST_WB : ST_RD;
                end
                ST_RD: st <= ST_WR;
                ST_WR: begin
                  if (ctl_q[CTL_SINC]) sptr <= sptr + step_sz;
                  if (ctl_q[CTL_DINC]) dptr <= dptr + step_sz;
                  items_q <= items_q - 8'd1;
                  st      <= (items_q == 8'd1) ? ST_WB : ST_RD;
                end
                default: st <= ST_FIN;
              endcase
            end
          end
        end
      endcase
    end
  end

  assign done_o       = (st == ST_FIN);
  assign err_o        = (st == ST_CHK) && misaligned;
  assign fin_o        = done_o || err_o;
  assign fin_expire_o = done_o && (cnt_new == 8'd0);
  assign svc_src_o    = src_q;

  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) &&
      $stable(mem_write_o) && $stable(mem_wdata_o)));
  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r3_aligned_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CB) |-> (base_q[2:0] == 3'd0));
  a_r3_err_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |=> !mem_valid_o);
endmodule

// File: rtl/mts_server.sv
module mts_server #(
  parameter int          NSRC     = 4,
  parameter int          AW       = 16,
  parameter logic [15:0] VEC_BASE = 16'h0040,
  localparam int SW = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] irq_i,
  input  logic [NSRC-1:0] sel_set_i,
  input  logic [NSRC-1:0] srv_clr_i,
  output logic [NSRC-1:0] sel_o,
  output logic [NSRC-1:0] srv_o,
  output logic [NSRC-1:0] bypass_o,
  output logic            done_o,
  output logic            err_o,
  output logic [SW-1:0]   svc_src_o,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic            mem_write_o,
  output logic [AW-1:0]   mem_addr_o,
  output logic [7:0]      mem_wdata_o,
  input  logic            mem_rvalid_i,
  input  logic [7:0]      mem_rdata_i
);
  logic [NSRC-1:0] pend, eligible;
  logic            pick_valid, fin, fin_expire;
  logic [SW-1:0]   pick_idx;

  assign eligible = pend & sel_o;

  mts_src_regs #(.NSRC(NSRC)) u_regs (
    .clk, .rst_n, .irq_i, .sel_set_i, .srv_clr_i,
    .fin_i(fin), .fin_src_i(svc_src_o), .fin_expire_i(fin_expire),
    .pend_o(pend), .sel_o, .srv_o, .bypass_o
  );

  mts_prio_pick #(.NSRC(NSRC)) u_pick (
    .req_i(eligible), .gnt_valid_o(pick_valid), .gnt_idx_o(pick_idx)
  );

  mts_engine #(.NSRC(NSRC), .AW(AW), .VEC_BASE(VEC_BASE)) u_eng (
    .clk, .rst_n,
    .pick_valid_i(pick_valid), .pick_idx_i(pick_idx),
    .mem_valid_o, .mem_ready_i, .mem_write_o, .mem_addr_o, .mem_wdata_o,
    .mem_rvalid_i, .mem_rdata_i,
    .done_o, .err_o, .svc_src_o, .fin_o(fin), .fin_expire_o(fin_expire)
  );

  a_r1_lowest_first: assert property (@(posedge clk) disable iff (!rst_n)
    pick_valid |-> (eligible[pick_idx] &&
      ((eligible & ((NSRC'(1) << pick_idx) - NSRC'(1))) == '0)));
endmodule

// File: tb/tb_mts_server.sv
module tb_mts_server;
  localparam int          NSRC = 4;
  localparam int          AW   = 16;
  localparam logic [15:0] VB   = 16'h0040;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [3:0]  irq = '0, sel_set = '0, srv_clr = '0;
  logic [3:0]  sel_o, srv_o, bypass_o;
  logic        done_o, err_o;
  logic [1:0]  svc_src;
  logic        mem_valid, mem_ready, mem_write, mem_rvalid;
  logic [15:0] mem_addr, raddr;
  logic [7:0]  mem_wdata, mem_rdata;
  int          lat;

  mts_server #(.NSRC(NSRC), .AW(AW), .VEC_BASE(VB)) dut (
    .clk, .rst_n, .irq_i(irq), .sel_set_i(sel_set), .srv_clr_i(srv_clr),
    .sel_o, .srv_o, .bypass_o, .done_o, .err_o, .svc_src_o(svc_src),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_write_o(mem_write),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata)
  );

  logic [7:0] mem [0:511];
  logic [7:0] em  [0:511];
  int checks = 0, fails = 0, ev = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // RAM with random back-pressure and read latency
  always @(posedge clk) begin
    if (!rst_n) begin
      mem_ready <= 1'b0; mem_rvalid <= 1'b0; lat <= 0;
    end else begin
      mem_ready  <= ($urandom % 4) != 0;
      mem_rvalid <= 1'b0;
      if (lat != 0) begin
        lat <= lat - 1;
        if (lat == 1) begin
          mem_rvalid <= 1'b1;
          mem_rdata  <= mem[raddr[8:0]];
        end
      end
      if (mem_valid && mem_ready) begin
        if (mem_write) mem[mem_addr[8:0]] <= mem_wdata;
        else begin raddr <= mem_addr; lat <= 1 + ($urandom % 3); end
      end
    end
  end

  // reference model
  logic [3:0] m_sel, m_srv, m_pend, m_byp, h_done, h_exp;
  logic       p_done, p_v, p_r, p_w;
  logic [15:0] p_a;
  logic [7:0]  p_d;

  function automatic int lowest(logic [3:0] m);
    for (int i = 0; i < 4; i++) if (m[i]) return i;
    return 0;
  endfunction

  // R2 vector, R4 layout, R5 sizes/increments, R6 block count, R7 write-back
  function automatic void serve(int s, output bit err, output bit exp);
    int base, cnt, sp, dp, items, sz;
    logic [7:0] ctl, tmp0, tmp1;
    base = em[(VB + 2*s) & 511] | (em[(VB + 2*s + 1) & 511] << 8);
    err = (base % 8) != 0;
    exp = 1'b0;
    if (err) return;
    cnt = em[base & 511]; ctl = em[(base+1) & 511];
    sp = em[(base+2) & 511] | (em[(base+3) & 511] << 8);
    dp = em[(base+4) & 511] | (em[(base+5) & 511] << 8);
    items = ctl[3] ? int'(em[(base+6) & 511]) : 1;
    sz = ctl[0] ? 2 : 1;
    for (int it = 0; it < items; it++) begin
      tmp0 = em[sp & 511]; tmp1 = em[(sp+1) & 511];
      em[dp & 511] = tmp0;
      if (sz == 2) em[(dp+1) & 511] = tmp1;
      if (ctl[1]) sp = (sp + sz) & 16'hFFFF;
      if (ctl[2]) dp = (dp + sz) & 16'hFFFF;
    end
    cnt = (cnt - 1) & 255;
    em[base & 511] = 8'(cnt);
    em[(base+2) & 511] = 8'(sp); em[(base+3) & 511] = 8'(sp >> 8);
    em[(base+4) & 511] = 8'(dp); em[(base+5) & 511] = 8'(dp >> 8);
    exp = (cnt == 0);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      chk(sel_o == m_sel, "R12", "sel", sel_o, m_sel);
      chk(srv_o == m_srv, "R8", "srv", srv_o, m_srv);
      chk(bypass_o == m_byp, "R9", "bypass", bypass_o, m_byp);
      if (p_v && !p_r)
        chk(mem_valid && mem_addr == p_a && mem_write == p_w && mem_wdata == p_d,
            "R11", "held request addr", mem_addr, p_a);
      if (done_o || err_o) begin
        int s, mism;
        bit e, x;
        s = lowest(m_pend & m_sel);
        chk(svc_src == 2'(s), "R1", "served source", svc_src, s);
        chk(!(done_o && err_o) && !p_done, "R10", "single done", done_o, 1);
        serve(s, e, x);
        chk(err_o == e, "R3", "error flag", err_o, e);
        mism = 0;
        for (int a = 0; a < 512; a++) if (mem[a] !== em[a]) mism++;
        chk(mism == 0, "R2/R4/R5/R6/R7", "RAM mismatching bytes", mism, 0);
        h_done = 4'(1 << s);
        h_exp  = (x && !e) ? 4'(1 << s) : 4'b0;
        ev++;
      end
    end
    p_done = done_o; p_v = mem_valid; p_r = mem_ready;
    p_a = mem_addr; p_w = mem_write; p_d = mem_wdata;
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sel = '0; m_srv = '0; m_pend = '0; m_byp = '0; h_done = '0; h_exp = '0;
    end else begin
      logic [3:0] so;
      so     = m_sel;
      m_pend = (m_pend & ~h_done) | (irq & so);
      m_sel  = (m_sel | sel_set) & ~h_exp;
      m_srv  = (m_srv & ~srv_clr) | h_exp;
      m_byp  = irq & ~so;
      h_done = '0; h_exp = '0;
    end
  end

  task automatic put(int a, logic [7:0] v);
    mem[a] = v; em[a] = v;
  endtask

  task automatic fire(logic [3:0] m, int events);
    int target;
    target = ev + events;
    @(negedge clk); #1 irq = m;
    @(negedge clk); #1 irq = '0;
    while (ev < target) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic quiet_irq(logic [3:0] m, string req);
    @(negedge clk); #1 irq = m;
    @(negedge clk); #1 irq = '0;
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      chk(!mem_valid, req, "no RAM traffic", mem_valid, 0);
    end
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    for (int a = 0; a < 512; a++) put(a, (a >= 256) ? 8'((a * 7 + 3) & 255) : 8'h00);
    // vector table
    put(VB + 0, 8'h80); put(VB + 2, 8'h88); put(VB + 4, 8'h90); put(VB + 6, 8'h9C);
    // src0: word, both increment, single
    put(8'h80, 8'd2); put(8'h81, 8'h07); put(8'h82, 8'h00); put(8'h83, 8'h01);
    put(8'h84, 8'h80); put(8'h85, 8'h01);
    // src1: byte block of 3, src increment, dst fixed
    put(8'h88, 8'd1); put(8'h89, 8'h0A); put(8'h8A, 8'h10); put(8'h8B, 8'h01);
    put(8'h8C, 8'h90); put(8'h8D, 8'h01); put(8'h8E, 8'd3);
    // src2: word block of 2, src fixed, dst increment
    put(8'h90, 8'd3); put(8'h91, 8'h0D); put(8'h92, 8'h20); put(8'h93, 8'h01);
    put(8'h94, 8'hA0); put(8'h95, 8'h01); put(8'h96, 8'd2);

    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(sel_o == 4'h0 && srv_o == 4'h0, "R12", "reset sel/srv", {sel_o, srv_o}, 0);
    chk(!done_o && !err_o && !mem_valid, "R10", "reset idle", {done_o, err_o, mem_valid}, 0);

    quiet_irq(4'b0010, "R9");                 // unselected -> bypass only
    @(negedge clk); #1 sel_set = 4'b1111;
    @(negedge clk); #1 sel_set = '0;

    fire(4'b0001, 1);                         // src0 word move, count 2->1
    fire(4'b0101, 2);                         // R1: src0 (expires) before src2
    quiet_irq(4'b0001, "R8");                 // expired source now bypasses
    @(negedge clk); #1 srv_clr = 4'b0001;
    @(negedge clk); #1 srv_clr = '0;
    fire(4'b0010, 1);                         // src1 byte block, expires
    fire(4'b1000, 1);                         // src3 misaligned -> R3 error
    fire(4'b0100, 1);
    fire(4'b0100, 1);                         // src2 expires
    // re-arm src2 with zero-length block
    @(negedge clk); #1 put(8'h90, 8'd1); put(8'h96, 8'd0);
    sel_set = 4'b0100;
    @(negedge clk); #1 sel_set = '0;
    fire(4'b0100, 1);                         // R6 zero length, R8 expiry
    repeat (4) @(negedge clk);
    finish_run();
  end
endmodule